// File: doc/BRIEF.md
# Programmable AND-OR Logic Array

This block is a two-plane programmable logic array. A configurable AND plane builds a pool of product terms from the block inputs. Each term may use the true or the complemented form of any input. A configurable OR plane then builds each output as the OR of any subset of that pool. A single product term can therefore drive several outputs at once, so a shared term costs one row and not one row per output.

Both planes live in configuration registers. They are loaded through one addressed write port: a plane select, a row index and a data word, qualified by a write strobe. Evaluation from inputs to outputs is purely combinational.

Reset leaves every row empty. Empty rows are defined to be inactive: an empty product term reads 0, and an output with nothing selected reads 0.

Top module: `prog_sop_array`

## Requirements
- R1: After a synchronous active-low reset, every AND row and every OR row is empty, so every output is 0 for every input pattern.
- R2: In AND row t, bit 2i selects the true form of input i and bit 2i+1 selects its complemented form. Product term t is 1 exactly when every selected literal is satisfied and at least one literal is selected.
- R3: An AND row with no literal selected yields a product term of 0.
- R4: An AND row that selects both the true and the complemented literal of the same input yields a product term of 0.
- R5: In OR row o, bit j selects product term j. Output o is the OR of the selected terms.
- R6: An output whose OR row selects no term drives 0.
- R7: One product term selected by several OR rows drives all of those outputs together.
- R8: A write is applied at the rising clock edge that samples the strobe high. Plane select 0 addresses the AND plane and plane select 1 addresses the OR plane. Outputs reflect the new row only after that edge. When the strobe is low, no row changes.
- R9: A write whose row index is outside the addressed plane (OR rows at index 4 or above with the default sizes) changes no row.
- R10: Outputs follow input changes combinationally, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Synchronous active-low reset, clears both planes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_plane | input | 1 | Plane select: 0 = AND plane, 1 = OR plane |
| cfg_row | input | 3 | Row index within the selected plane |
| cfg_data | input | 8 | Row contents (2·N_IN bits for AND rows, N_TERM bits for OR rows) |
| din | input | 4 | Logic inputs |
| dout | output | 4 | Logic outputs |

## Verification
An input change is due at the outputs in the same cycle with no clock edge in between. The bench therefore drives each input in the low clock phase and samples 1 ns later, before the next rising edge. A configuration write is due one edge later. The bench checks the old behaviour while the strobe is still high and before the edge, then checks the new behaviour after the following falling edge. Ignored writes and low-strobe cycles are judged at the outputs one full edge later. In these checks an input pattern is chosen so that any aliased or wrongly applied row would change a visible output bit.

// File: rtl/pla_pkg.sv
// Package: shared types for the programmable AND-OR array.
// Assumes: a one-bit plane select on the configuration port.
package pla_pkg;

    typedef enum logic {
        PLANE_AND = 1'b0,
        PLANE_OR  = 1'b1
    } plane_e;

    // Smallest index width able to address `count` rows (never below 1).
    function automatic int idx_width(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/pla_cfg_store.sv
// Module: configuration registers for both planes.
// Decodes the addressed write port into per-row enables. Out-of-range
// rows never match a decode, so such writes are dropped.
// Assumes: DATA_W >= 2*N_IN and DATA_W >= N_TERM; synchronous active-low reset.
module pla_cfg_store
    import pla_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int N_TERM = 8,
    parameter int N_OUT  = 4,
    parameter int ROW_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cfg_we,
    input  logic                                cfg_plane,
    input  logic [ROW_W-1:0]                    cfg_row,
    input  logic [DATA_W-1:0]                   cfg_data,
    output logic [N_TERM-1:0][2*N_IN-1:0]       and_cfg,
    output logic [N_OUT-1:0][N_TERM-1:0]        or_cfg
);

    localparam int AND_W = 2 * N_IN;

    logic hit_and;
    logic hit_or;

    // Qualify the strobe with the plane select.
    always_comb begin
        hit_and = cfg_we && (cfg_plane == PLANE_AND);
        hit_or  = cfg_we && (cfg_plane == PLANE_OR);
    end

    genvar r;
    generate
        for (r = 0; r < N_TERM; r++) begin : g_and_row
            logic wr_en;
            assign wr_en = hit_and && (cfg_row == ROW_W'(r));

            // Hold or load one AND-plane row.
            always_ff @(posedge clk) begin
                if (!rst_n)     and_cfg[r] <= '0;
                else if (wr_en) and_cfg[r] <= cfg_data[AND_W-1:0];
            end

            // R8
            and_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we && cfg_plane == 1'b0 && cfg_row == ROW_W'(r))
                |=> (and_cfg[r] == $past(cfg_data[AND_W-1:0])));
            // R8
            and_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(cfg_we && cfg_plane == 1'b0 && cfg_row == ROW_W'(r))
                |=> $stable(and_cfg[r]));
            // R1
            and_clear_chk: assert property (@(posedge clk)
                !rst_n |=> (and_cfg[r] == '0));
        end

        for (r = 0; r < N_OUT; r++) begin : g_or_row
            logic wr_en;
            assign wr_en = hit_or && (cfg_row == ROW_W'(r));

            // Hold or load one OR-plane row.
            always_ff @(posedge clk) begin
                if (!rst_n)     or_cfg[r] <= '0;
                else if (wr_en) or_cfg[r] <= cfg_data[N_TERM-1:0];
            end

            // R8
            or_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we && cfg_plane == 1'b1 && cfg_row == ROW_W'(r))
                |=> (or_cfg[r] == $past(cfg_data[N_TERM-1:0])));
            // R9
            or_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(cfg_we && cfg_plane == 1'b1 && cfg_row == ROW_W'(r))
                |=> $stable(or_cfg[r]));
            // R1
            or_clear_chk: assert property (@(posedge clk)
                !rst_n |=> (or_cfg[r] == '0));
        end
    endgenerate

endmodule

// File: rtl/pla_and_plane.sv
// Module: AND plane. Each row holds one bit pair per input:
// even bit = true literal, odd bit = complemented literal.
// An empty row evaluates to 0. A row holding both literals of one input
// evaluates to 0 as a natural consequence.
// Assumes: purely combinational, rows are stable between writes.
module pla_and_plane #(
    parameter int N_IN   = 4,
    parameter int N_TERM = 8
) (
    input  logic [N_TERM-1:0][2*N_IN-1:0] and_cfg,
    input  logic [N_IN-1:0]               din,
    output logic [N_TERM-1:0]             terms
);

    genvar t;
    generate
        for (t = 0; t < N_TERM; t++) begin : g_term
            logic [N_IN-1:0] lit_ok;

            // Per input: every selected literal must be satisfied.
            always_comb begin
                for (int i = 0; i < N_IN; i++) begin
                    lit_ok[i] = (!and_cfg[t][2*i]   ||  din[i]) &&
                                (!and_cfg[t][2*i+1] || !din[i]);
                end
            end

            // An unused row is forced low instead of reading as a wide AND of ones.
            assign terms[t] = (|and_cfg[t]) && (&lit_ok);
        end
    endgenerate

endmodule

// File: rtl/pla_or_plane.sv
// Module: OR plane. Output o is the OR of the terms its row selects.
// Any term may feed any number of outputs.
// Assumes: purely combinational; an empty row drives 0.
module pla_or_plane #(
    parameter int N_TERM = 8,
    parameter int N_OUT  = 4
) (
    input  logic [N_OUT-1:0][N_TERM-1:0] or_cfg,
    input  logic [N_TERM-1:0]            terms,
    output logic [N_OUT-1:0]             dout
);

    genvar o;
    generate
        for (o = 0; o < N_OUT; o++) begin : g_out
            // Gate the term pool with this output's row and reduce.
            assign dout[o] = |(or_cfg[o] & terms);
        end
    endgenerate

endmodule

// File: rtl/prog_sop_array.sv
// Module: top of the programmable AND-OR array.
// Configuration registers feed a combinational AND plane and OR plane.
// Assumes: synchronous active-low reset; writes land on the sampling edge.
module prog_sop_array
    import pla_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int N_TERM = 8,
    parameter int N_OUT  = 4,
    localparam int AND_W  = 2 * N_IN,
    localparam int DATA_W = (AND_W > N_TERM) ? AND_W : N_TERM,
    localparam int ROW_W  = idx_width((N_TERM > N_OUT) ? N_TERM : N_OUT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_plane,
    input  logic [ROW_W-1:0]  cfg_row,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic [N_IN-1:0]   din,
    output logic [N_OUT-1:0]  dout
);

    logic [N_TERM-1:0][AND_W-1:0]  and_cfg;
    logic [N_OUT-1:0][N_TERM-1:0]  or_cfg;
    logic [N_TERM-1:0]             terms;

    pla_cfg_store #(
        .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT),
        .ROW_W(ROW_W), .DATA_W(DATA_W)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_plane(cfg_plane),
        .cfg_row(cfg_row), .cfg_data(cfg_data),
        .and_cfg(and_cfg), .or_cfg(or_cfg)
    );

    pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) and_i (
        .and_cfg(and_cfg), .din(din), .terms(terms)
    );

    pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) or_i (
        .or_cfg(or_cfg), .terms(terms), .dout(dout)
    );

    genvar t, o;
    generate
        for (t = 0; t < N_TERM; t++) begin : g_term_chk
            logic [N_IN-1:0] clash;
            // Flag inputs whose true and complemented literal are both selected.
            always_comb begin
                for (int i = 0; i < N_IN; i++)
                    clash[i] = and_cfg[t][2*i] && and_cfg[t][2*i+1];
            end

            // R3
            empty_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (and_cfg[t] == '0) |-> !terms[t]);
            // R4
            clash_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (|clash) |-> !terms[t]);
        end

        for (o = 0; o < N_OUT; o++) begin : g_out_chk
            // R6
            empty_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (or_cfg[o] == '0) |-> !dout[o]);
            // R5
            out_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
                dout[o] |-> (|(or_cfg[o] & terms)));
        end
    endgenerate

endmodule

// File: tb/prog_sop_array_tb.sv
`timescale 1ns/1ps
// Bench: loads F1/F2/F3 with shared terms, walks a vector table, then
// runs directed checks for reset, write timing, ignored writes and empty rows.
module prog_sop_array_tb_top;

    localparam real CLK_NS = 8.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_plane = 1'b0;
    logic [2:0] cfg_row = '0;
    logic [7:0] cfg_data = '0;
    logic [3:0] din = '0;
    logic [3:0] dout;

    int checks = 0;
    int errors = 0;

    // Inputs {a,b,c,d} = din[3:0]; expected dout = {0, F3, F2, F1}.
    localparam logic [3:0] EXP_TBL [16] = '{
        4'h0, 4'h0, 4'h3, 4'h3, 4'h0, 4'h3, 4'h6, 4'h7,
        4'h5, 4'h5, 4'h3, 4'h3, 4'h0, 4'h5, 4'h6, 4'h7
    };

    prog_sop_array dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_plane(cfg_plane),
        .cfg_row(cfg_row), .cfg_data(cfg_data), .din(din), .dout(dout)
    );

    always #(CLK_NS / 2.0) clk = ~clk;

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Drive the inputs in the low phase and compare 1 ns later.
    task automatic check_out(input logic [3:0] pat, input logic [3:0] exp, input string req);
        din = pat;
        #1;
        checks++;
        if (dout !== exp) begin
            errors++;
            $display("FAIL %s din=%h actual=%h expected=%h", req, pat, dout, exp);
        end
    endtask

    // One-cycle write: strobe high across a single rising edge.
    task automatic write_row(input logic plane, input logic [2:0] row, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_plane = plane; cfg_row = row; cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset leaves every output low.
        @(negedge clk);
        check_out(4'h0, 4'h0, "R1");
        check_out(4'hF, 4'h0, "R1");
        check_out(4'h7, 4'h0, "R1");

        // AND rows: t0=a'bd t1=abd t2=ab'c' t3=b'c t4=c t5=bc t6=a&a' t7=empty.
        write_row(1'b0, 3'd0, 8'h91);
        write_row(1'b0, 3'd1, 8'h51);
        write_row(1'b0, 3'd2, 8'h68);
        write_row(1'b0, 3'd3, 8'h24);
        write_row(1'b0, 3'd4, 8'h04);
        write_row(1'b0, 3'd5, 8'h14);
        write_row(1'b0, 3'd6, 8'hC0);
        // OR rows: F1, F2, F3 share t0, t1, t2; output 3 sees only t6 and t7.
        write_row(1'b1, 3'd0, 8'h0F);
        write_row(1'b1, 3'd1, 8'h11);
        write_row(1'b1, 3'd2, 8'h26);
        write_row(1'b1, 3'd3, 8'hC0);

        // R2 R5 R7 (shared terms) and R3 R4 (output 3 stays low).
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            check_out(4'(v), EXP_TBL[v], "R2/R5/R7 R3 R4");
        end

        // R10: input change seen without a clock edge.
        @(negedge clk);
        check_out(4'h6, 4'h6, "R10");
        check_out(4'h8, 4'h5, "R10");

        // R8: the new row shows only after the sampling edge.
        @(negedge clk);
        din = 4'h6;
        cfg_we = 1'b1; cfg_plane = 1'b1; cfg_row = 3'd2; cfg_data = 8'h00;
        #1;
        checks++;
        if (dout !== 4'h6) begin
            errors++;
            $display("FAIL R8 before edge actual=%h expected=%h", dout, 4'h6);
        end
        @(negedge clk);
        cfg_we = 1'b0;
        check_out(4'h6, 4'h2, "R8");
        write_row(1'b1, 3'd2, 8'h26);
        check_out(4'h6, 4'h6, "R8");

        // R8: strobe low changes nothing.
        @(negedge clk);
        cfg_plane = 1'b1; cfg_row = 3'd0; cfg_data = 8'h00;
        @(negedge clk);
        check_out(4'h2, 4'h3, "R8");

        // R9: OR rows 4..7 are outside the plane; no aliasing onto rows 0..3.
        write_row(1'b1, 3'd4, 8'hFF);
        write_row(1'b1, 3'd5, 8'hFF);
        write_row(1'b1, 3'd6, 8'hFF);
        write_row(1'b1, 3'd7, 8'hFF);
        check_out(4'h6, 4'h6, "R9");
        check_out(4'h2, 4'h3, "R9");

        // R6: give t7 literal d (output 3 follows d), then empty OR row 3.
        write_row(1'b0, 3'd7, 8'h01);
        check_out(4'h1, 4'h8, "R6");
        write_row(1'b1, 3'd3, 8'h00);
        check_out(4'h1, 4'h0, "R6");
        check_out(4'h7, 4'h7, "R6");

        // R1: reset again clears both planes.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_out(4'h7, 4'h0, "R1");
        check_out(4'h8, 4'h0, "R1");

        finish_run();
    end

endmodule